// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing controller of a 512-byte nonvolatile store that sits on a two-wire serial bus as a slave. A fast system clock oversamples the bus clock and data lines. The controller finds start and stop conditions and matches the slave-address byte against two select straps. It then takes a word address and buffers up to a page of write data, or streams read data out from an internal address counter. The data line is never driven high. The block only asserts an enable that pulls it low.

Written bytes are held in a one-page buffer and reach the array only after a stop condition. A stop starts a self-timed write cycle whose length is a parameter. For the whole of that cycle the block ignores the bus. The array is an ordinary register file, and the timed cycle is modelled by a counter.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the data-line pull enable is off, the block is idle and no write cycle is running.
- R2: The address byte is taken MSB first as: bits 7..4 = 1010, bit 3 compared with `dev_sel[1]`, bit 2 compared with `dev_sel[0]`, bit 1 = memory address bit 8 (used on writes, not compared with any pin), bit 0 = direction (1 read, 0 write).
- R3: When the type code or either select bit differs, the block gives no acknowledge and returns to idle.
- R4: Before a start condition is seen, any bus traffic is ignored and the data line is never pulled.
- R5: The block acknowledges by pulling the data line low during the 9th clock after a matching address byte, after the word address and after every write data byte. Its pull enable changes only while the bus clock is low.
- R6: Write data reach the array only when a stop condition ends a write that carried at least one data byte. A stop that comes before any data byte writes nothing and starts no write cycle. A repeated start discards buffered data.
- R7: For `WR_CYCLES` system clocks after a committing stop, the block neither acknowledges nor drives the bus. After that it responds normally.
- R8: In a page write, the low 4 address bits advance after each data byte and wrap within the 16-byte page, while the upper address bits stay fixed.
- R9: During a read, the address counter advances after each byte and wraps from 511 to 0. A read without a word-address phase starts at the current counter value, and in that case bit 1 of the address byte is ignored.
- R10: When the master does not acknowledge a read byte, the block releases the data line and sends nothing more until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| dev_sel | input | 2 | Select straps matched against address bits 3 and 2 |
| sda_pull | output | 1 | When high, the data line is pulled low |

## Verification
The hardest state to reach is the window just after a committing stop, while the self-timed write cycle is still running. A probe transaction must land inside this window and must be seen to get no acknowledge. The bench shortens the cycle to a few thousand clocks and sends a full address byte straight after the stop. It then waits out the cycle and repeats the probe. A second hard case is the wrap of the read counter from 511 to 0, followed by a current-address read. The bench sets this up by writing both ends of the array in separate commits, starting a read at the last location, and checking that a later read without an address phase continues from location 1.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel,
  output logic       sda_pull
);
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int TW     = $clog2(WR_CYCLES + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_WORD = 3'd2,
                         S_WDAT = 3'd3, S_RD  = 3'd4, S_HOLD = 3'd5,
                         S_BUSY = 3'd6;

  logic [2:0]        scl_p, sda_p;
  logic [2:0]        st, nxt;
  logic [3:0]        bcnt;
  logic [7:0]        sh, tx;
  logic [ADDR_W-1:0] addr;
  logic [PAGE-1:0]   mask;
  logic [TW-1:0]     tmr;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire busy   = (st == S_BUSY);
  wire idle   = (st == S_IDLE);
  wire rx_st  = (st == S_DEV) | (st == S_WORD) | (st == S_WDAT);
  wire commit = busy && (tmr == TW'(WR_CYCLES - 1));
  wire dev_hit = (sh[7:4] == 4'hA) && (sh[3:2] == dev_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; bcnt <= '0; sh <= '0; tx <= '0;
      addr <= '0; mask <= '0; tmr <= '0; sda_pull <= 1'b0;
    end else if (busy) begin
      if (commit) begin
        st  <= S_IDLE;
        tmr <= '0;
      end else tmr <= tmr + 1'b1;
    end else if (start) begin
      st <= S_DEV; bcnt <= '0; mask <= '0; sda_pull <= 1'b0;
    end else if (stop) begin
      bcnt     <= '0;
      sda_pull <= 1'b0;
      st       <= (st == S_WDAT && |mask) ? S_BUSY : S_IDLE;
    end else begin
      case (st)
        S_DEV, S_WORD, S_WDAT: begin
          if (scl_rise && bcnt < 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 1'b1;
          end else if (scl_fall && bcnt == 4'd8) begin
            bcnt     <= 4'd9;
            sda_pull <= 1'b1;
            case (st)
              S_DEV:
                if (dev_hit) begin
                  nxt <= sh[0] ? S_RD : S_WORD;
                  if (!sh[0]) addr[ADDR_W-1] <= sh[1];
                end else begin
                  st <= S_IDLE; bcnt <= '0; sda_pull <= 1'b0;
                end
              S_WORD: begin
                addr[ADDR_W-2:0] <= sh;
                nxt <= S_WDAT;
              end
              default: begin
                pbuf[addr[PAGE_W-1:0]] <= sh;
                mask[addr[PAGE_W-1:0]] <= 1'b1;
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                nxt <= S_WDAT;
              end
            endcase
          end else if (scl_fall && bcnt == 4'd9) begin
            bcnt     <= '0;
            st       <= nxt;
            tx       <= mem[addr];
            sda_pull <= (nxt == S_RD) ? ~mem[addr][7] : 1'b0;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            if (bcnt < 4'd8) bcnt <= bcnt + 1'b1;
            else if (bcnt == 4'd9) begin
              if (sda_s) begin
                st <= S_HOLD; bcnt <= '0;
              end else bcnt <= 4'd10;
            end
          end else if (scl_fall) begin
            if (bcnt >= 4'd1 && bcnt <= 4'd7) begin
              tx       <= {tx[6:0], 1'b0};
              sda_pull <= ~tx[6];
            end else if (bcnt == 4'd8) begin
              sda_pull <= 1'b0;
              addr     <= addr + 1'b1;
              bcnt     <= 4'd9;
            end else if (bcnt == 4'd10) begin
              tx       <= mem[addr];
              sda_pull <= ~mem[addr][7];
              bcnt     <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (mask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
  parameter int WR_CYCLES = 1,
  parameter int TW        = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pull,
  input logic          scl_s,
  input logic          busy,
  input logic          idle,
  input logic          rx_st,
  input logic [3:0]    bcnt,
  input logic [TW-1:0] tmr
);
  AST_BUSY_SILENT:   assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_pull);                 // R7
  AST_BUSY_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) busy |-> (tmr < TW'(WR_CYCLES)));    // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !sda_pull);                 // R4
  AST_PULL_SCL_LOW:  assert property (@(posedge clk) disable iff (!rst_n) scl_s |=> $stable(sda_pull));        // R5
  AST_ACK_SLOT:      assert property (@(posedge clk) disable iff (!rst_n) (rx_st && sda_pull) |-> bcnt == 4'd9); // R5
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_s(scl_s), .busy(busy),
  .idle(idle), .rx_st(rx_st), .bcnt(bcnt), .tmr(tmr)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;
  localparam int WR = 2000;
  localparam int Q  = 10;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;
  int   checks = 0;
  int   errors = 0;
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  twi_eeprom_slave #(.PAGE_W(4), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel(SEL), .sda_pull(sda_pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dbyte(input logic [1:0] s, input bit a8, input bit rw);
    return {4'hA, s, a8, rw};
  endfunction

  task automatic b_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rx_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    tick(Q); sda_m = 1'b1;
  endtask

  task automatic addr_phase(input logic [8:0] a, output bit ok);
    bit k1, k2;
    b_start();
    tx_byte(dbyte(SEL, a[8], 1'b0), k1);
    tx_byte(a[7:0], k2);
    ok = k1 & k2;
  endtask

  task automatic wr_run(input logic [8:0] a, input int n, input logic [7:0] d0,
                        input logic [7:0] stp, input string req);
    bit ok, k;
    int nacks = 0;
    addr_phase(a, ok);
    for (int i = 0; i < n; i++) begin
      tx_byte(8'(d0 + i * stp), k);
      if (!k) nacks++;
    end
    b_stop();
    check(ok && nacks == 0, req, nacks, 0);
    tick(WR + 100);
  endtask

  task automatic rd_run(input logic [8:0] a, input int n);
    bit ok, k;
    addr_phase(a, ok);
    b_start();
    tx_byte(dbyte(SEL, 1'b0, 1'b1), k);
    check(ok && k, "R9 read addressing acked", {ok, k}, 3);
    for (int j = 0; j < n; j++) rx_byte(rbuf[j], j < n - 1);
    b_stop();
  endtask

  task automatic t_reset();
    check(sda_pull == 1'b0, "R1 pull off after reset", sda_pull, 0);
    check(sda_line == 1'b1, "R1 line released after reset", sda_line, 1);
  endtask

  task automatic t_no_start();
    bit k;
    tx_byte(dbyte(SEL, 1'b0, 1'b0), k);
    check(!k, "R4 no ack without start", k, 0);
    b_stop();
  endtask

  task automatic t_mismatch();
    bit k;
    b_start(); tx_byte(dbyte(2'b01, 1'b0, 1'b0), k); b_stop();
    check(!k, "R3 select mismatch not acked", k, 0);
    b_start(); tx_byte({4'hB, SEL, 2'b00}, k); b_stop();
    check(!k, "R3 type code mismatch not acked", k, 0);
  endtask

  task automatic t_byte_write_busy();
    bit ok, k;
    addr_phase(9'h1A5, ok);
    check(ok, "R2 R5 address and word acked", ok, 1);
    tx_byte(8'h3C, k);
    check(k, "R5 data byte acked", k, 1);
    b_stop();
    b_start(); tx_byte(dbyte(SEL, 1'b0, 1'b0), k); b_stop();
    check(!k, "R7 no ack during write cycle", k, 0);
    tick(WR + 200);
    b_start(); tx_byte(dbyte(SEL, 1'b0, 1'b0), k); b_stop();
    check(k, "R7 ack after write cycle", k, 1);
    wr_run(9'h0A5, 1, 8'h5A, 8'h00, "R2 low-half write acked");
    rd_run(9'h1A5, 1);
    check(rbuf[0] == 8'h3C, "R2 R6 high-half byte", rbuf[0], 8'h3C);
    rd_run(9'h0A5, 1);
    check(rbuf[0] == 8'h5A, "R2 low-half byte", rbuf[0], 8'h5A);
  endtask

  task automatic t_page();
    wr_run(9'h03C, 16, 8'h80, 8'h01, "R8 page bytes acked");
    rd_run(9'h030, 16);
    for (int j = 0; j < 16; j++) begin
      logic [7:0] e;
      e = 8'h80 + 8'((j - 12) & 15);
      check(rbuf[j] == e, "R8 page wrap contents", rbuf[j], e);
    end
  endtask

  task automatic t_no_data_and_restart();
    bit ok, k;
    addr_phase(9'h077, ok); b_stop();
    b_start(); tx_byte(dbyte(SEL, 1'b0, 1'b0), k); b_stop();
    check(k, "R6 stop before data starts no cycle", k, 1);
    addr_phase(9'h0A5, ok); tx_byte(8'hEE, k);
    b_start(); tx_byte(dbyte(SEL, 1'b0, 1'b0), k); b_stop();
    b_start(); tx_byte(dbyte(SEL, 1'b0, 1'b0), k); b_stop();
    check(k, "R6 restart discards buffer, no cycle", k, 1);
    rd_run(9'h0A5, 1);
    check(rbuf[0] == 8'h5A, "R6 discarded write left byte", rbuf[0], 8'h5A);
  endtask

  task automatic t_wrap_current_nack();
    bit k;
    int lows = 0;
    logic [7:0] b;
    wr_run(9'h1FF, 1, 8'h11, 8'h00, "R9 top byte written");
    wr_run(9'h000, 2, 8'h22, 8'h11, "R9 bottom bytes written");
    rd_run(9'h1FF, 2);
    check(rbuf[0] == 8'h11, "R9 read at 511", rbuf[0], 8'h11);
    check(rbuf[1] == 8'h22, "R9 wrap to 0", rbuf[1], 8'h22);
    b_start(); tx_byte(dbyte(SEL, 1'b1, 1'b1), k);
    check(k, "R9 current read acked", k, 1);
    rx_byte(b, 1'b0);
    check(b == 8'h33, "R9 current address read", b, 8'h33);
    for (int i = 0; i < 9; i++) begin
      tick(Q); scl_m = 1'b1;
      for (int t = 0; t < 2*Q; t++) begin
        tick(1);
        if (!sda_line) lows++;
      end
      scl_m = 1'b0;
      tick(Q);
      if (!sda_line) lows++;
    end
    check(lows == 0, "R10 silent after master nack", lows, 0);
    b_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_no_start();
    t_mismatch();
    t_byte_write_busy();
    t_page();
    t_no_data_and_restart();
    t_wrap_current_nack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule